// File: doc/BRIEF.md
# Serial/Parallel Configuration Data Streamer

The block is the read side of a configuration store that feeds a programmable logic device. A byte array inside the block is filled through a simple synchronous write port. A stepping clock from outside moves an address counter through the array. Each step puts out one bit on data line 0 in serial mode, or one byte on the 8-bit data bus in parallel mode. The highest address ever written marks the end of the image. At that address the counter stops and holds, so the outputs keep the final value.

The block has two independent controls that each clear the counter and float the data bus. One is an active-high chip-enable, whose high level means standby. The other is an active-low output-enable/reset line. This line is open-drain and bidirectional. The block pulls it low by itself for a fixed number of system clocks after power-on reset, and any other agent on the board can also pull it low. A separate open-drain configuration-request output gives a low pulse of programmable length each time the command input is seen, so that an attached device can restart its configuration.

The counter sequencer has four named states. WALK_CLEAR is entered whenever the output-enable/reset line is low. WALK_IDLE is entered whenever chip-enable is high while that line is high. WALK_RUN applies when the block is enabled and below the end address. WALK_HOLD applies when it is enabled and at or past the end address. Every state can move to any other state on the next system clock: a low output-enable/reset line selects WALK_CLEAR, a high chip-enable selects WALK_IDLE, and an enabled block selects WALK_RUN or WALK_HOLD by comparing the counter with the end address.

Top module: `cfg_streamer`

## Requirements
- R1: The counter advances by one on a rising edge of `step_clk` only while `standby` is low and `oe_rst_n` is high. Without such an edge the counter does not change.
- R2: While `oe_rst_n` is low, the counter is forced to zero and all eight `dq` lines are high-Z. When the line returns high, the output starts again from address 0.
- R3: While `standby` is high, the counter is forced to zero and all eight `dq` lines are high-Z. Step edges in standby have no effect.
- R4: When `par_mode` is 0, the counter addresses bits. `dq[0]` carries bit 7−(n mod 8) of byte n/8, so each byte goes out most-significant bit first, and `dq[7:1]` stay high-Z.
- R5: When `par_mode` is 1, the counter addresses bytes, and `dq[7:0]` drive the stored byte at the counter address.
- R6: After `rst_n` is released, the block pulls `oe_rst_n` low for POR_CYCLES (default 4) system clocks and then releases it. The block never drives `oe_rst_n` high.
- R7: Each clock on which `cfg_cmd` is high starts or restarts a low pulse on `cfg_req_n` that lasts PULSE_CYCLES (default 8) clocks. A single command gives exactly 8 low cycles, and a command issued k cycles into a pulse gives k+8 low cycles in total. The block never drives `cfg_req_n` high.
- R8: The counter stops at the end address and does not wrap. The end address is the last bit of the highest written byte in serial mode, or the highest written byte in parallel mode. The outputs keep driving the final value.
- R9: When `wr_en` is high at a clock edge, `wr_data` is stored at `wr_addr`, and the end address becomes the larger of its old value and `wr_addr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| wr_en | input | 1 | Write strobe for the byte store |
| wr_addr | input | ADDR_W | Byte address for a write |
| wr_data | input | 8 | Byte to store |
| step_clk | input | 1 | External stepping clock; rising edges advance the counter |
| standby | input | 1 | Active-high chip-enable control; high means standby |
| par_mode | input | 1 | 1 = parallel byte output, 0 = serial bit output |
| cfg_cmd | input | 1 | Configuration command; high starts or restarts the request pulse |
| oe_rst_n | inout | 1 | Open-drain active-low output-enable/reset line |
| cfg_req_n | output | 1 | Open-drain active-low configuration-request pulse |
| dq | output | 8 | Tri-state data bus; bit 0 is the serial output |

## Verification
The assertions assume that `step_clk` is slow compared with `clk` and synchronous to it, so each high and each low phase lasts at least one system clock. They also assume that `par_mode` does not change while the image is being walked unless the counter is cleared first. The bench changes every input on the falling edge of `clk`, holds each level of `step_clk` for a full system clock, and clears the counter through standby before it switches modes. Both open-drain lines and the data bus are pulled up in the bench, so a high-Z line reads as 1.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
    typedef enum logic [1:0] {
        WALK_CLEAR = 2'd0,
        WALK_IDLE  = 2'd1,
        WALK_RUN   = 2'd2,
        WALK_HOLD  = 2'd3
    } walk_state_t;
endpackage

// File: rtl/cfg_por.sv
module cfg_por #(
    parameter int POR_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic hold
);
    localparam int CW = $clog2(POR_CYCLES + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (cnt < CW'(POR_CYCLES))
            cnt <= cnt + 1'b1;
    end

    assign hold = (cnt < CW'(POR_CYCLES));

    // R6
    por_release_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hold |=> !hold);
endmodule

// File: rtl/cfg_store.sv
module cfg_store #(
    parameter int DEPTH  = 64,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic [ADDR_W-1:0] top_addr
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en)
            mem[wr_addr] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            top_addr <= '0;
        else if (wr_en && (wr_addr > top_addr))
            top_addr <= wr_addr;
    end

    assign rd_data = mem[rd_addr];

    // R9
    top_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (top_addr >= $past(wr_addr)));
endmodule

// File: rtl/cfg_walker.sv
module cfg_walker
    import cfg_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int CW     = ADDR_W + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_clk,
    input  logic              line_ok,
    input  logic              standby,
    input  logic              par_mode,
    input  logic [ADDR_W-1:0] top_addr,
    output logic [CW-1:0]     cnt,
    output logic              drive_en
);
    walk_state_t state, state_nx;
    logic        step_q;
    logic        step_rise;
    logic        enabled;
    logic [CW-1:0] limit;
    logic          at_end;

    assign step_rise = step_clk & ~step_q;
    assign enabled   = line_ok & ~standby;
    assign limit     = par_mode ? {3'b000, top_addr} : {top_addr, 3'b111};
    assign at_end    = (cnt >= limit);

    always_comb begin
        state_nx = state;
        unique case (state)
            WALK_CLEAR, WALK_IDLE, WALK_RUN, WALK_HOLD: begin
                if (!line_ok)
                    state_nx = WALK_CLEAR;
                else if (standby)
                    state_nx = WALK_IDLE;
                else if (at_end || (step_rise && (cnt + 1'b1 >= limit)))
                    state_nx = WALK_HOLD;
                else
                    state_nx = WALK_RUN;
            end
            default: state_nx = WALK_CLEAR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= WALK_CLEAR;
        else
            state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_q <= 1'b0;
            cnt    <= '0;
        end else begin
            step_q <= step_clk;
            if (!enabled)
                cnt <= '0;
            else if (step_rise && !at_end)
                cnt <= cnt + 1'b1;
        end
    end

    always_comb begin
        unique case (state)
            WALK_RUN, WALK_HOLD: drive_en = enabled;
            default:             drive_en = 1'b0;
        endcase
    end

    // R1
    step_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enabled && !step_rise) |=> $stable(cnt));
    // R2
    line_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !line_ok |=> (cnt == '0));
    // R3
    standby_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        standby |=> (cnt == '0));
    // R8
    end_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enabled && at_end) |=> $stable(cnt));
    // R2
    float_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !line_ok |-> !drive_en);
endmodule

// File: rtl/cfg_pulse.sv
module cfg_pulse #(
    parameter int PULSE_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd,
    output logic active
);
    localparam int PW = $clog2(PULSE_CYCLES + 1);

    logic [PW-1:0] left;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            left <= '0;
        else if (cmd)
            left <= PW'(PULSE_CYCLES);
        else if (left != '0)
            left <= left - 1'b1;
    end

    assign active = (left != '0);

    // R7
    pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd |=> active);
endmodule

// File: rtl/cfg_streamer.sv
module cfg_streamer #(
    parameter int DEPTH        = 64,
    parameter int POR_CYCLES   = 4,
    parameter int PULSE_CYCLES = 8,
    parameter int ADDR_W       = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              step_clk,
    input  logic              standby,
    input  logic              par_mode,
    input  logic              cfg_cmd,
    inout  wire               oe_rst_n,
    output logic              cfg_req_n,
    output logic [7:0]        dq
);
    localparam int CW = ADDR_W + 3;

    logic              por_hold;
    logic              line_ok;
    logic              drive_en;
    logic              req_active;
    logic [CW-1:0]     cnt;
    logic [ADDR_W-1:0] top_addr;
    logic [ADDR_W-1:0] rd_addr;
    logic [7:0]        rd_data;
    logic              ser_bit;
    logic [7:0]        out_byte;

    cfg_por #(.POR_CYCLES(POR_CYCLES)) u_por (
        .clk   (clk),
        .rst_n (rst_n),
        .hold  (por_hold)
    );

    assign oe_rst_n = por_hold ? 1'b0 : 1'bz;
    assign line_ok  = (oe_rst_n === 1'b1);

    cfg_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .top_addr (top_addr)
    );

    cfg_walker #(.ADDR_W(ADDR_W), .CW(CW)) u_walk (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_clk (step_clk),
        .line_ok  (line_ok),
        .standby  (standby),
        .par_mode (par_mode),
        .top_addr (top_addr),
        .cnt      (cnt),
        .drive_en (drive_en)
    );

    cfg_pulse #(.PULSE_CYCLES(PULSE_CYCLES)) u_pulse (
        .clk    (clk),
        .rst_n  (rst_n),
        .cmd    (cfg_cmd),
        .active (req_active)
    );

    assign cfg_req_n = req_active ? 1'b0 : 1'bz;

    assign rd_addr  = par_mode ? cnt[ADDR_W-1:0] : cnt[CW-1:3];
    assign ser_bit  = rd_data[~cnt[2:0]];
    assign out_byte = par_mode ? rd_data : {7'b0, ser_bit};

    assign dq[0] = drive_en ? out_byte[0] : 1'bz;

    for (genvar g = 1; g < 8; g++) begin : g_bus
        assign dq[g] = (drive_en && par_mode) ? out_byte[g] : 1'bz;
    end

    // R6
    por_pull_chk: assert property (@(posedge clk) disable iff (!rst_n)
        por_hold |-> !line_ok);
endmodule

// File: tb/test_cfg_streamer.sv
module test_cfg_streamer;
    localparam int ADDR_W = 6;
    localparam int NB     = 6;
    localparam logic [7:0] PAT [NB] = '{8'hA5, 8'h3C, 8'hF0, 8'h0F, 8'h96, 8'h81};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [7:0]        wr_data = '0;
    logic              step_clk = 1'b0;
    logic              standby = 1'b0;
    logic              par_mode = 1'b1;
    logic              cfg_cmd = 1'b0;
    logic              tb_oe_low = 1'b0;
    wire               oe_line;
    wire               req_line;
    wire  [7:0]        dq;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    int req_low_cnt = 0;

    pullup (oe_line);
    pullup (req_line);
    for (genvar g = 0; g < 8; g++) begin : g_pu
        pullup (dq[g]);
    end

    assign oe_line = tb_oe_low ? 1'b0 : 1'bz;

    cfg_streamer i_cfg_streamer (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .step_clk  (step_clk),
        .standby   (standby),
        .par_mode  (par_mode),
        .cfg_cmd   (cfg_cmd),
        .oe_rst_n  (oe_line),
        .cfg_req_n (req_line),
        .dq        (dq)
    );

    always #10 clk = ~clk;

    always @(negedge clk) if (req_line == 1'b0) req_low_cnt++;

    task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic dpulse;
        @(negedge clk) step_clk = 1'b1;
        @(negedge clk) step_clk = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 50000);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic exp_bit;
        // R6: line held low in reset and during the power-on window
        repeat (2) @(negedge clk);
        chk(oe_line == 1'b0, "R6 reset", {7'b0, oe_line}, 8'h00);
        chk(dq == 8'hFF, "R2 float in reset", dq, 8'hFF);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(oe_line == 1'b0, "R6 hold", {7'b0, oe_line}, 8'h00);
        @(negedge clk);
        chk(oe_line == 1'b1, "R6 release", {7'b0, oe_line}, 8'h01);

        // R9: load the store from the table
        for (int i = 0; i < NB; i++) begin
            wr_en = 1'b1; wr_addr = ADDR_W'(i); wr_data = PAT[i];
            @(negedge clk);
        end
        wr_en = 1'b0;
        standby = 1'b1; @(negedge clk);
        standby = 1'b0; repeat (2) @(negedge clk);

        // R5 R9 R1: walk the table in parallel mode
        for (int i = 0; i < NB; i++) begin
            chk(dq == PAT[i], "R5 parallel byte", dq, PAT[i]);
            dpulse();
        end
        chk(dq == PAT[NB-1], "R8 parallel end hold", dq, PAT[NB-1]);
        dpulse();
        chk(dq == PAT[NB-1], "R8 no wrap", dq, PAT[NB-1]);

        // R3: standby floats the bus and clears; steps ignored
        @(negedge clk) standby = 1'b1;
        @(negedge clk);
        chk(dq == 8'hFF, "R3 standby float", dq, 8'hFF);
        dpulse();
        chk(dq == 8'hFF, "R3 standby step", dq, 8'hFF);
        standby = 1'b0;
        @(negedge clk);
        chk(dq == PAT[0], "R3 restart at 0", dq, PAT[0]);
        dpulse();
        chk(dq == PAT[1], "R1 advance one", dq, PAT[1]);
        repeat (3) @(negedge clk);
        chk(dq == PAT[1], "R1 no edge no move", dq, PAT[1]);

        // R2: external pull-down on the line
        tb_oe_low = 1'b1;
        @(negedge clk);
        chk(dq == 8'hFF, "R2 line low float", dq, 8'hFF);
        dpulse();
        chk(dq == 8'hFF, "R2 step ignored", dq, 8'hFF);
        tb_oe_low = 1'b0;
        @(negedge clk);
        chk(oe_line == 1'b1, "R6 never driven", {7'b0, oe_line}, 8'h01);
        chk(dq == PAT[0], "R2 restart at 0", dq, PAT[0]);

        // R4: serial walk, MSB first
        standby = 1'b1; par_mode = 1'b0;
        @(negedge clk);
        standby = 1'b0;
        @(negedge clk);
        for (int b = 0; b < NB * 8; b++) begin
            exp_bit = PAT[b / 8][7 - (b % 8)];
            chk(dq[0] == exp_bit, "R4 serial bit", {7'b0, dq[0]}, {7'b0, exp_bit});
            chk(dq[7:1] == 7'h7F, "R4 upper float", {1'b0, dq[7:1]}, 8'h7F);
            dpulse();
        end
        chk(dq[0] == PAT[NB-1][0], "R8 serial end hold", {7'b0, dq[0]}, {7'b0, PAT[NB-1][0]});

        // R7: single request pulse
        req_low_cnt = 0;
        cfg_cmd = 1'b1;
        @(negedge clk) cfg_cmd = 1'b0;
        repeat (15) @(negedge clk);
        chk(req_low_cnt == 8, "R7 single pulse", 8'(req_low_cnt), 8'd8);
        chk(req_line == 1'b1, "R7 released", {7'b0, req_line}, 8'h01);

        // R7: restart three cycles into a pulse
        req_low_cnt = 0;
        cfg_cmd = 1'b1;
        @(negedge clk) cfg_cmd = 1'b0;
        repeat (2) @(negedge clk);
        cfg_cmd = 1'b1;
        @(negedge clk) cfg_cmd = 1'b0;
        repeat (15) @(negedge clk);
        chk(req_low_cnt == 11, "R7 retrigger", 8'(req_low_cnt), 8'd11);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule